// File: doc/BRIEF.md
# Read-First Dual-Port RAM Wrapper

This block is a simple dual-port RAM with one synchronous write port and one synchronous read port on a single clock. A read that lands on the same address as a write in the same cycle returns the contents from before that write. The write, however, is never presented to the storage in the cycle it arrives. Address, data and lane enables are held for one cycle in a register stage. The inner array's read path forwards any delayed write that hits the read address, lane by lane. Because the write reaches the array one edge late, a read issued alongside it still sees the old word. A read issued on the next cycle sees the new word through the forwarding path.

Byte-lane enables may be grouped. When several lanes are always driven from the same source, one delay flop serves the whole group, and the per-lane enables are rebuilt after the delay. The wrapper can run on either clock edge. The edge choice for the write side and the read side must match, and a mismatch stops elaboration.

Top module: `rdfirst_ram`

## Requirements
- R1: While reset is high and on the first cycle after it, no write reaches the storage. `rd_data` reads 0 after reset until the first enabled read.
- R2: A read whose address matches a write issued in the same cycle returns the word as it was before that write.
- R3: A read issued one or more cycles after a write to the same address returns the written data.
- R4: Only lanes whose `wr_be` bit is 1 are updated. Lane k is `wr_data[8k+7:8k]`, and the other lanes keep their contents.
- R5: When `rd_en` is 0, `rd_data` holds its previous value.
- R6: Writes to one address leave the data read from any other address unchanged.
- R7: With `LANE_GROUP` = G, the enable of each group of G adjacent lanes is taken from the lowest lane of the group and applies to all G lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | LANES | Per-lane write enables, where 0 on all lanes means no write |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
`rd_data` is due one clock edge after the read is sampled. The bench drives on the falling edge and compares on the following falling edge, so each result is checked exactly once, half a period after the register updates. A write becomes visible to a read sampled on the next rising edge. The reference model therefore captures the read value before applying that cycle's write, which mirrors the read-first contract without modelling the internal delay. Lane-group behaviour is checked on a second instance with groups of two, using fixed expected words.

// File: rtl/rdfirst_pkg.sv
package rdfirst_pkg;

    localparam int MAX_LANES = 16;

    typedef logic [MAX_LANES-1:0] lane_vec_t;

    function automatic int group_count(input int lanes, input int grp);
        return (lanes + grp - 1) / grp;
    endfunction

    // pick the lowest-lane enable of each group
    function automatic lane_vec_t fold_lanes(input lane_vec_t be, input int lanes, input int grp);
        lane_vec_t r;
        r = '0;
        for (int g = 0; g < MAX_LANES; g++) begin
            if (g * grp < lanes) r[g] = be[g * grp];
        end
        return r;
    endfunction

    // rebuild per-lane enables from group enables
    function automatic lane_vec_t spread_lanes(input lane_vec_t gen, input int lanes, input int grp);
        lane_vec_t r;
        r = '0;
        for (int l = 0; l < MAX_LANES; l++) begin
            if (l < lanes) r[l] = gen[l / grp];
        end
        return r;
    endfunction

endpackage

// File: rtl/rdfirst_wr_delay.sv
module rdfirst_wr_delay
    import rdfirst_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int LANES      = 4,
    parameter int LANE_GROUP = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_be,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_be
);
    localparam int GROUPS = group_count(LANES, LANE_GROUP);

    lane_vec_t         be_wide;
    lane_vec_t         folded;
    lane_vec_t         grp_wide;
    lane_vec_t         spread;
    logic [GROUPS-1:0] grp_q;

    always_comb begin
        be_wide = '0;
        be_wide[LANES-1:0] = in_be;
        folded = fold_lanes(be_wide, LANES, LANE_GROUP);
    end

    // enable stage: cleared by reset so nothing is written early
    always_ff @(posedge clk) begin
        if (rst) grp_q <= '0;
        else     grp_q <= folded[GROUPS-1:0];
    end

    // address and data need no reset
    always_ff @(posedge clk) begin
        out_addr <= in_addr;
        out_data <= in_data;
    end

    always_comb begin
        grp_wide = '0;
        grp_wide[GROUPS-1:0] = grp_q;
        spread = spread_lanes(grp_wide, LANES, LANE_GROUP);
    end

    assign out_be = spread[LANES-1:0];

endmodule

// File: rtl/rdfirst_store.sv
module rdfirst_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wa,
    input  logic [DATA_W-1:0] wd,
    input  logic [LANES-1:0]  wbe,
    input  logic              re,
    input  logic [ADDR_W-1:0] ra,
    output logic [DATA_W-1:0] rq
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] fwd;
    logic              hit;

    assign hit = (wa == ra);

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (wbe[l]) cells[wa][l*LANE_W +: LANE_W] <= wd[l*LANE_W +: LANE_W];
        end
    end

    // transparent read: forward the lanes being written this edge
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd[l*LANE_W +: LANE_W] = (hit && wbe[l]) ? wd[l*LANE_W +: LANE_W]
                                                         : cells[ra][l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (rst)     rq <= '0;
        else if (re) rq <= fwd;
    end

endmodule

// File: rtl/rdfirst_ram.sv
module rdfirst_ram
    import rdfirst_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 32,
    parameter int LANES      = 4,
    parameter int LANE_GROUP = 1,
    parameter bit WR_RISING  = 1'b1,
    parameter bit RD_RISING  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    if (WR_RISING != RD_RISING) begin : g_bad_clk
        $error("rdfirst_ram: read and write ports must use the same clock edge");
    end
    if (DATA_W % LANES != 0 || LANES > MAX_LANES || LANES % LANE_GROUP != 0) begin : g_bad_lanes
        $error("rdfirst_ram: lane configuration does not divide evenly");
    end

    logic core_clk;
    if (WR_RISING) begin : g_pos
        assign core_clk = clk;
    end else begin : g_neg
        assign core_clk = ~clk;
    end

    logic [ADDR_W-1:0] dly_addr;
    logic [DATA_W-1:0] dly_data;
    logic [LANES-1:0]  dly_be;

    rdfirst_wr_delay #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .LANE_GROUP(LANE_GROUP)
    ) u_dly (
        .clk(core_clk), .rst(rst),
        .in_addr(wr_addr), .in_data(wr_data), .in_be(wr_be),
        .out_addr(dly_addr), .out_data(dly_data), .out_be(dly_be)
    );

    rdfirst_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
    ) u_store (
        .clk(core_clk), .rst(rst),
        .wa(dly_addr), .wd(dly_data), .wbe(dly_be),
        .re(rd_en), .ra(rd_addr), .rq(rd_data)
    );

endmodule

// File: rtl/rdfirst_chk.sv
module rdfirst_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [LANES-1:0]  wr_be,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] dly_addr,
    input logic [DATA_W-1:0] dly_data,
    input logic [LANES-1:0]  dly_be
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == '0 && dly_be == '0));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));

    // R3
    dly_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(|wr_be)) |-> (dly_addr == $past(wr_addr) && dly_data == $past(wr_data)));

    // R7
    dly_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_be) == '0) |-> dly_be == '0);

endmodule

bind rdfirst_ram rdfirst_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
) u_chk (
    .clk(core_clk), .rst(rst),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_en(rd_en), .rd_data(rd_data),
    .dly_addr(dly_addr), .dly_data(dly_data), .dly_be(dly_be)
);

// File: tb/sim_rdfirst_ram.sv
`timescale 1ns/1ps
module sim_rdfirst_ram;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int LN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [LN-1:0] wr_be = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] rd_data_g;

    always #2 clk = ~clk;

    rdfirst_ram u0 (
        .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    rdfirst_ram #(.LANE_GROUP(2)) u1 (
        .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_g)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DW-1:0] ref_mem [1 << AW];
    bit            known   [1 << AW];
    logic [DW-1:0] exp_rd = '0;
    bit            exp_ok = 1'b1;

    // {be, waddr, wdata, rd_en, raddr}
    localparam logic [48:0] VEC [8] = '{
        {4'hF, 6'd2, 32'hDEADBEEF, 1'b1, 6'd2},
        {4'h0, 6'd0, 32'h00000000, 1'b1, 6'd2},
        {4'h3, 6'd3, 32'h12345678, 1'b1, 6'd4},
        {4'h0, 6'd0, 32'h00000000, 1'b1, 6'd3},
        {4'hF, 6'd3, 32'h00000001, 1'b1, 6'd3},
        {4'hF, 6'd3, 32'h00000002, 1'b1, 6'd3},
        {4'hF, 6'd5, 32'hCAFEF00D, 1'b0, 6'd5},
        {4'h0, 6'd0, 32'h00000000, 1'b1, 6'd3}
    };
    localparam string TAG [8] = '{"R2", "R3", "R6", "R4", "R2", "R2", "R5", "R3"};

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [LN-1:0] be, input logic [AW-1:0] wa,
                        input logic [DW-1:0] wd, input logic re, input logic [AW-1:0] ra);
        wr_be = be; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        if (re) begin
            exp_rd = ref_mem[ra];
            exp_ok = known[ra];
        end
        for (int l = 0; l < LN; l++) begin
            if (be[l]) ref_mem[wa][l*8 +: 8] = wd[l*8 +: 8];
        end
        if (be == 4'hF) known[wa] = 1'b1;
        tick();
        if (exp_ok) check(req, rd_data, exp_rd);
        wr_be = '0; rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int a = 0; a < (1 << AW); a++) begin
            ref_mem[a] = '0;
            known[a] = 1'b0;
        end
        @(negedge clk);
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1", rd_data, '0);
        check("R1", rd_data_g, '0);

        for (int a = 0; a < 16; a++) step("R3", 4'hF, 6'(a), 32'hA0A0_A000 + 32'(a), 1'b0, '0);
        // R5 no reads yet, output still holds reset value
        check("R5", rd_data, '0);

        for (int i = 0; i < 8; i++) begin
            step(TAG[i], VEC[i][48:45], VEC[i][44:39], VEC[i][38:7], VEC[i][6], VEC[i][5:0]);
        end

        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 400; i++) begin
            logic [2:0] wa;
            logic [2:0] ra;
            logic [LN-1:0] be;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            wa = lfsr[2:0];
            ra = (lfsr[7:6] == 2'b00) ? lfsr[5:3] : wa;
            be = lfsr[11:8];
            step((wa == ra && be != 0) ? "R2" : "R6", be, 6'(wa), {lfsr[15:0], lfsr[31:16]},
                 lfsr[12] | lfsr[13], 6'(ra));
        end

        // R1 writes presented during reset are dropped
        step("R3", 4'hF, 6'd9, 32'h0000_0055, 1'b0, '0);
        step("R3", 4'h0, 6'd0, '0, 1'b0, '0);
        rst = 1'b1; wr_be = 4'hF; wr_addr = 6'd9; wr_data = 32'h0000_0BAD;
        tick(); tick();
        rst = 1'b0; wr_be = '0;
        tick();
        check("R1", rd_data, '0);
        exp_rd = '0;
        step("R1", 4'h0, 6'd0, '0, 1'b1, 6'd9);

        // R7 lane groups of two on u1
        step("R3", 4'hF, 6'd12, 32'h0000_0000, 1'b0, '0);
        step("R4", 4'b0101, 6'd12, 32'hFFFF_FFFF, 1'b0, '0);
        step("R4", 4'h0, 6'd0, '0, 1'b1, 6'd12);
        check("R7", rd_data_g, 32'hFFFF_FFFF);
        step("R4", 4'b1010, 6'd12, 32'h1111_1111, 1'b0, '0);
        step("R4", 4'h0, 6'd0, '0, 1'b1, 6'd12);
        check("R7", rd_data_g, 32'hFFFF_FFFF);
        check("R4", rd_data, 32'h11FF_11FF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule